// File: doc/BRIEF.md
# Delay-Line Lock and Freeze Sequencer

This block brings up the delay-locked loop of a DDR PHY and then pins it to the delay it measured. After a one-cycle start pulse, it issues a fixed series of writes. First comes the parameter word with the loop stopped. Then a fixed setting goes to the auxiliary PHY register. The loop is then switched on, and finally it is started.

Once the loop is started, the block polls the PHY status word until every lock flag is set. It copies the measured delay count from the status word into the force field of the control word and writes that word back, so the loop holds the fixed value. When built with the release option, one more write turns the loop enable off while the forced value and the start bit stay in place. A programmable poll limit guards the wait for lock. If lock never comes, the block raises a failure flag and goes back to idle without writing a frozen word.

Each word leaves the block together with a write strobe that is high for one cycle. The status outputs hold their value until the next accepted start pulse.

Top module: `dll_freeze_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `ctl_we_o`, `aux_we_o`, `done_o` and `lock_fail_o` are low.
- R2: An accepted start produces four writes on consecutive cycles, each strobed for one cycle. (1) The parameter word, with the start point in bits 15:8, the increment in bits 23:16 (both 0x10 by default) and bits 1:0 = 00; with the defaults this is 0x00101000. (2) The auxiliary write. (3) The same word with bit 1 (loop enable) set. (4) The same word with bits 1:0 = 11.
- R3: The auxiliary write carries 0x86 when `MEM_KIND` = 0 and 0x84 when `MEM_KIND` = 1.
- R4: Lock is recognised only when status bits 2:0 are all one. Any other pattern, such as 011, keeps the block polling.
- R5: In the cycle after lock is seen, the block writes the frozen word. Bits 31:24 hold status bits 13:6 from the lock cycle, bits 23:8 hold the increment and start point, and bits 1:0 = 11.
- R6: With `DLL_OFF_AFTER` = 1, the next cycle writes the frozen word again with bit 1 cleared and bit 0 still set. With `DLL_OFF_AFTER` = 0, no such write occurs.
- R7: If lock is not seen within `lock_tmo_i` poll cycles, `lock_fail_o` goes high, no frozen word is written, and the block returns to idle. `lock_fail_o` stays high until the next accepted start.
- R8: `done_o` rises after the last write of a successful run and stays high until the next accepted start. It is never high together with `lock_fail_o`.
- R9: A start pulse that arrives while a sequence is running is ignored and causes no extra write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| phy_stat_i | input | STAT_W | PHY status word: lock flags in bits 2:0, measured delay in bits 13:6 |
| lock_tmo_i | input | TMO_W | Maximum number of poll cycles to wait for lock |
| ctl_wdata_o | output | CTL_W | Control word for the main PHY control register |
| ctl_we_o | output | 1 | One-cycle write strobe for `ctl_wdata_o` |
| aux_wdata_o | output | AUX_W | Fixed setting for the auxiliary PHY control register |
| aux_we_o | output | 1 | One-cycle write strobe for `aux_wdata_o` |
| done_o | output | 1 | Set after a successful freeze, held until the next start |
| lock_fail_o | output | 1 | Set when the poll limit expired, held until the next start |

## Verification
A delay-line model in the bench answers the start write after a chosen delay. Until it locks it reports a partial flag pattern (011), and it fills the unused status bits with noise.

The runs cover several cases:
- Immediate lock and delayed lock, which together separate correct polling from an early capture.
- Measured values of 0x00, 0xFF and mixed patterns, which show whether the force field is taken from the right status bits.
- A run with no lock at all, which tells the timeout path apart from a freeze.
- A second start pulse during polling, which shows whether a running sequence can be restarted.

Two instances with opposite memory-kind and release settings run side by side, which separates the two auxiliary values and the presence or absence of the release write.

// File: rtl/dll_frz_pkg.sv
package dll_frz_pkg;
   // control word field positions
   localparam int GO_BIT    = 0;
   localparam int EN_BIT    = 1;
   localparam int SP_LSB    = 8;
   localparam int INC_LSB   = 16;
   localparam int FRC_LSB   = 24;
   // status word field positions
   localparam int LOCK_W    = 3;
   localparam int MEAS_LSB  = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PARAM,
      ST_AUX,
      ST_ON,
      ST_RUN,
      ST_POLL,
      ST_FRZ,
      ST_OFF
   } seq_st_t;
endpackage

// File: rtl/dll_word_fmt.sv
module dll_word_fmt
   import dll_frz_pkg::*;
#(
   parameter int              CTL_W    = 32,
   parameter int              FIELD_W  = 8,
   parameter logic [FIELD_W-1:0] START_PT = 8'h10,
   parameter logic [FIELD_W-1:0] INCR     = 8'h10
) (
   input  seq_st_t            st,
   input  logic [FIELD_W-1:0] frc,
   output logic [CTL_W-1:0]   word,
   output logic               ctl_we,
   output logic               aux_we
);
   localparam logic [CTL_W-1:0] BASE =
      (CTL_W'(INCR) << INC_LSB) | (CTL_W'(START_PT) << SP_LSB);
   localparam logic [CTL_W-1:0] EN_M = CTL_W'(1) << EN_BIT;
   localparam logic [CTL_W-1:0] GO_M = CTL_W'(1) << GO_BIT;

   logic [CTL_W-1:0] frc_w;
   assign frc_w = CTL_W'(frc) << FRC_LSB;

   always_comb begin
      word   = '0;
      ctl_we = 1'b0;
      aux_we = 1'b0;
      case (st)
         ST_PARAM: begin word = BASE;                       ctl_we = 1'b1; end
         ST_AUX:   begin                                    aux_we = 1'b1; end
         ST_ON:    begin word = BASE | EN_M;                ctl_we = 1'b1; end
         ST_RUN:   begin word = BASE | EN_M | GO_M;         ctl_we = 1'b1; end
         ST_FRZ:   begin word = BASE | frc_w | EN_M | GO_M; ctl_we = 1'b1; end
         ST_OFF:   begin word = BASE | frc_w | GO_M;        ctl_we = 1'b1; end
         default:  begin end
      endcase
   end
endmodule

// File: rtl/dll_poll_timer.sv
module dll_poll_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W:0]   nxt;

   assign nxt     = {1'b0, cnt_q} + (TMO_W+1)'(1);
   assign expired = run && (nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (run)     cnt_q <= nxt[TMO_W-1:0];
   end
endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
   import dll_frz_pkg::*;
#(
   parameter int FIELD_W       = 8,
   parameter bit DLL_OFF_AFTER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LOCK_W-1:0]  lock_flags,
   input  logic [FIELD_W-1:0] meas,
   input  logic               expired,
   output seq_st_t            st,
   output logic [FIELD_W-1:0] frc,
   output logic               tmr_clr,
   output logic               tmr_run,
   output logic               done,
   output logic               fail
);
   seq_st_t st_q;
   seq_st_t frz_next;
   seq_st_t last_st;
   logic    locked;

   generate
      if (DLL_OFF_AFTER) begin : g_release
         assign frz_next = ST_OFF;
         assign last_st  = ST_OFF;
      end else begin : g_hold
         assign frz_next = ST_IDLE;
         assign last_st  = ST_FRZ;
      end
   endgenerate

   assign locked  = &lock_flags;
   assign tmr_clr = (st_q == ST_RUN);
   assign tmr_run = (st_q == ST_POLL) && !locked;
   assign st      = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         frc  <= '0;
         done <= 1'b0;
         fail <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q <= ST_PARAM;
               done <= 1'b0;
               fail <= 1'b0;
            end
            ST_PARAM: st_q <= ST_AUX;
            ST_AUX:   st_q <= ST_ON;
            ST_ON:    st_q <= ST_RUN;
            ST_RUN:   st_q <= ST_POLL;
            ST_POLL: begin
               if (locked) begin
                  frc  <= meas;
                  st_q <= ST_FRZ;
               end else if (expired) begin
                  fail <= 1'b1;
                  st_q <= ST_IDLE;
               end
            end
            ST_FRZ:   st_q <= frz_next;
            ST_OFF:   st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
         if (st_q == last_st) done <= 1'b1;
      end
   end
endmodule

// File: rtl/dll_freeze_ctrl.sv
module dll_freeze_ctrl
   import dll_frz_pkg::*;
#(
   parameter int                 CTL_W         = 32,
   parameter int                 STAT_W        = 32,
   parameter int                 FIELD_W       = 8,
   parameter int                 AUX_W         = 8,
   parameter int                 TMO_W         = 16,
   parameter logic [FIELD_W-1:0] START_PT      = 8'h10,
   parameter logic [FIELD_W-1:0] INCR          = 8'h10,
   parameter int                 MEM_KIND      = 0,
   parameter bit                 DLL_OFF_AFTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [STAT_W-1:0] phy_stat_i,
   input  logic [TMO_W-1:0]  lock_tmo_i,
   output logic [CTL_W-1:0]  ctl_wdata_o,
   output logic              ctl_we_o,
   output logic [AUX_W-1:0]  aux_wdata_o,
   output logic              aux_we_o,
   output logic              done_o,
   output logic              lock_fail_o
);
   localparam int MEAS_MSB = MEAS_LSB + FIELD_W - 1;

   generate
      if (CTL_W != FRC_LSB + FIELD_W) begin : g_bad_ctl
         $error("CTL_W must equal FRC_LSB + FIELD_W");
      end
      if (STAT_W <= MEAS_MSB) begin : g_bad_stat
         $error("STAT_W too narrow for measured field");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("TMO_W must be at least 2");
      end
      if (MEM_KIND != 0 && MEM_KIND != 1) begin : g_bad_kind
         $error("MEM_KIND must be 0 or 1");
      end
   endgenerate

   logic [AUX_W-1:0] aux_val;
   generate
      if (MEM_KIND == 0) begin : g_kind0
         assign aux_val = AUX_W'(8'h86);
      end else begin : g_kind1
         assign aux_val = AUX_W'(8'h84);
      end
   endgenerate

   seq_st_t            st;
   logic [FIELD_W-1:0] frc;
   logic               tmr_clr, tmr_run, expired;
   logic               aux_we;

   dll_poll_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .run     (tmr_run),
      .limit   (lock_tmo_i),
      .expired (expired)
   );

   dll_seq_fsm #(.FIELD_W(FIELD_W), .DLL_OFF_AFTER(DLL_OFF_AFTER)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .lock_flags (phy_stat_i[LOCK_W-1:0]),
      .meas       (phy_stat_i[MEAS_MSB:MEAS_LSB]),
      .expired    (expired),
      .st         (st),
      .frc        (frc),
      .tmr_clr    (tmr_clr),
      .tmr_run    (tmr_run),
      .done       (done_o),
      .fail       (lock_fail_o)
   );

   dll_word_fmt #(.CTL_W(CTL_W), .FIELD_W(FIELD_W), .START_PT(START_PT), .INCR(INCR)) u_fmt (
      .st     (st),
      .frc    (frc),
      .word   (ctl_wdata_o),
      .ctl_we (ctl_we_o),
      .aux_we (aux_we)
   );

   assign aux_we_o    = aux_we;
   assign aux_wdata_o = aux_we ? aux_val : '0;
endmodule

// File: rtl/dll_freeze_chk.sv
module dll_freeze_chk #(
   parameter int         CTL_W    = 32,
   parameter int         STAT_W   = 32,
   parameter logic [7:0] START_PT = 8'h10,
   parameter logic [7:0] INCR     = 8'h10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] phy_stat_i,
   input logic [CTL_W-1:0]  ctl_wdata_o,
   input logic              ctl_we_o,
   input logic              aux_we_o,
   input logic              done_o,
   input logic              lock_fail_o
);
   // R2
   aux_then_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_we_o |=> (ctl_we_o && ctl_wdata_o[1:0] == 2'b10));

   // R2
   fixed_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we_o |-> (ctl_wdata_o[23:8] == {INCR, START_PT}));

   // R5
   frz_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we_o && ctl_wdata_o[1:0] == 2'b11 && !$past(ctl_we_o) && !$past(aux_we_o))
      |-> (ctl_wdata_o[31:24] == $past(phy_stat_i[13:6]) && $past(phy_stat_i[2:0]) == 3'b111));

   // R6
   release_after_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we_o && ctl_wdata_o[1:0] == 2'b01)
      |-> ($past(ctl_we_o) && $past(ctl_wdata_o[1:0]) == 2'b11
           && ctl_wdata_o[31:24] == $past(ctl_wdata_o[31:24])));

   // R7
   fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_fail_o) |-> !$past(ctl_we_o));

   // R8
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !lock_fail_o);
endmodule

bind dll_freeze_ctrl dll_freeze_chk #(
   .CTL_W(CTL_W), .STAT_W(STAT_W), .START_PT(START_PT), .INCR(INCR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .phy_stat_i  (phy_stat_i),
   .ctl_wdata_o (ctl_wdata_o),
   .ctl_we_o    (ctl_we_o),
   .aux_we_o    (aux_we_o),
   .done_o      (done_o),
   .lock_fail_o (lock_fail_o)
);

// File: tb/tb_dll_freeze_ctrl.sv
module tb_dll_freeze_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] stat = '0;
   logic [15:0] tmo = 16'd100;

   always #2 clk = ~clk;

   logic [31:0] wa, wb;
   logic        wea, web, axa, axb, dna, dnb, fla, flb;
   logic [7:0]  ada, adb;

   dll_freeze_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .phy_stat_i(stat), .lock_tmo_i(tmo),
      .ctl_wdata_o(wa), .ctl_we_o(wea), .aux_wdata_o(ada), .aux_we_o(axa),
      .done_o(dna), .lock_fail_o(fla));

   dll_freeze_ctrl #(.MEM_KIND(1), .DLL_OFF_AFTER(1'b0)) dut_b (
      .clk(clk), .rst_n(rst_n), .start_i(start), .phy_stat_i(stat), .lock_tmo_i(tmo),
      .ctl_wdata_o(wb), .ctl_we_o(web), .aux_wdata_o(adb), .aux_we_o(axb),
      .done_o(dnb), .lock_fail_o(flb));

   typedef struct {bit aux; logic [31:0] d; string req;} exp_t;
   exp_t qa[$];
   exp_t qb[$];
   int checks = 0;
   int errors = 0;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic mon_one(ref exp_t q[$], input bit we, input bit ax, input logic [31:0] d);
      exp_t e;
      if (we || ax) begin
         if (q.size() == 0) chk(1'b0, "R9 unexpected write", d, 32'h0);
         else begin
            e = q.pop_front();
            chk(e.aux == ax && e.d == d, e.req, d, e.d);
         end
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         mon_one(qa, wea, axa, axa ? {24'h0, ada} : wa);
         mon_one(qb, web, axb, axb ? {24'h0, adb} : wb);
      end
   end

   // delay line model driven by the first instance's writes
   int          stub_lat = 0;
   logic [7:0]  stub_val = 8'h00;
   int          cnt = -1;
   always @(posedge clk) begin
      if (wea && wa[1:0] == 2'b00) begin
         stat <= {18'h2AAAA, 8'h5A, 3'b101, 3'b011};
         cnt  <= -1;
      end else if (wea && wa[1:0] == 2'b11 && stat[2:0] != 3'b111) begin
         cnt <= stub_lat;
      end else if (cnt > 0) begin
         cnt <= cnt - 1;
      end else if (cnt == 0) begin
         stat <= {18'h15555, stub_val, 3'b010, 3'b111};
         cnt  <= -1;
      end
   end

   function automatic exp_t mk(bit ax, logic [31:0] d, string r);
      exp_t e;
      e.aux = ax; e.d = d; e.req = r;
      return e;
   endfunction

   task automatic run(int lat, logic [7:0] val, logic [15:0] lim, bit lock, bit poke);
      stub_lat = lat;
      stub_val = val;
      tmo      = lim;
      qa.push_back(mk(0, 32'h00101000, "R2 param"));
      qa.push_back(mk(1, 32'h00000086, "R3 aux kind0"));
      qa.push_back(mk(0, 32'h00101002, "R2 enable"));
      qa.push_back(mk(0, 32'h00101003, "R2 start"));
      qb.push_back(mk(0, 32'h00101000, "R2 param"));
      qb.push_back(mk(1, 32'h00000084, "R3 aux kind1"));
      qb.push_back(mk(0, 32'h00101002, "R2 enable"));
      qb.push_back(mk(0, 32'h00101003, "R2 start"));
      if (lock) begin
         qa.push_back(mk(0, {val, 24'h101003}, "R5 freeze"));
         qa.push_back(mk(0, {val, 24'h101001}, "R6 release"));
         qb.push_back(mk(0, {val, 24'h101003}, "R5 freeze"));
      end
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(!fla && !dna, "R7 R8 cleared by start", {30'h0, fla, dna}, 32'h0);
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (!((dna || fla) && (dnb || flb))) @(negedge clk);
      @(negedge clk);
      if (lock) begin
         chk(dna && !fla && dnb && !flb, "R8 done", {28'h0, dna, fla, dnb, flb}, 32'ha);
         chk(qa.size() == 0 && qb.size() == 0, "R5 R6 all writes seen",
             32'(qa.size() + qb.size()), 32'h0);
         repeat (5) @(negedge clk);
         chk(dna && dnb, "R8 done held", {30'h0, dna, dnb}, 32'h3);
      end else begin
         chk(fla && !dna && flb && !dnb, "R7 lock_fail", {28'h0, dna, fla, dnb, flb}, 32'h5);
         chk(qa.size() == 0 && qb.size() == 0, "R7 no freeze write",
             32'(qa.size() + qb.size()), 32'h0);
         repeat (5) @(negedge clk);
         chk(fla && flb, "R7 fail held", {30'h0, fla, flb}, 32'h3);
      end
      if (poke) chk(qa.size() == 0, "R9 restart ignored", 32'(qa.size()), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!wea && !axa && !dna && !fla, "R1 reset", {28'h0, wea, axa, dna, fla}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!wea && !axa && !dna && !fla && !web && !flb, "R1 after reset",
          {26'h0, wea, axa, dna, fla, web, flb}, 32'h0);
      run(4,  8'h3C, 16'd100, 1'b1, 1'b0);   // R4 partial flags then lock
      run(0,  8'hFF, 16'd100, 1'b1, 1'b0);   // R5 immediate lock
      run(20, 8'h00, 16'd100, 1'b1, 1'b1);   // R9 start pulse mid-poll
      run(1000000, 8'h77, 16'd8, 1'b0, 1'b0); // R7 timeout
      run(7,  8'hA5, 16'd50, 1'b1, 1'b0);    // R5 recovery after failure
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule